// File: doc/BRIEF.md
# Double-Buffered Photon Arrival-Time Histogrammer

This block turns a stream of photon events, each tagged with a pixel number and a 10-bit arrival-time code, into one arrival-time histogram per pixel. One memory serves two neighbouring pixels. For each pixel it holds two full histogram copies, 128 bins of 16-bit counts each. At any moment one copy, the active bank, takes increments, while the other, the idle bank, can be drained.

A swap request exchanges the roles of the two banks. The bank that was accumulating is then streamed out, one bin per cycle. Each location is written back to zero right after it is read, so that bank is empty when it next becomes active. Acquisition never stops: events that arrive during a readout land in the new active bank. Memory port A only does read-modify-write accumulation. Port B only does readout and clearing, plus a one-time clear of the whole memory after reset.

Top module: `hist_pingpong_top`

## Requirements
- R1: After reset, `busy` is high for exactly 2**(1+PIX_W+BIN_W) cycles (512 by default) while the whole memory is cleared. During that time `active_bank` is 0 and `rd_valid` and `swap_err` are 0. Events presented during that time are not counted.
- R2: An event is counted in bin `ev_time[9:3]` of pixel `ev_pix` in the active bank. The three low bits of the time code do not affect the bin.
- R3: Events on consecutive cycles that hit the same pixel and bin are each counted, with no increment lost.
- R4: A bin count saturates at 0xFFFF and never wraps to zero.
- R5: A swap request while `busy` is low is accepted. `active_bank` toggles in the next cycle and `busy` rises. Starting three cycles after the request cycle, the previous bank is read out as 256 words on consecutive cycles, pixel 0 first, bins in ascending order, labelled by `rd_pix`/`rd_bin`. An event presented in the request cycle itself still belongs to the bank being read out.
- R6: Readout leaves every bin of the drained bank at zero. The next readout of that bank shows only events counted after it became active again.
- R7: A swap request while `busy` is high is ignored. `active_bank` stays unchanged, and `swap_err` is high for one cycle in the following cycle.
- R8: Events presented during a readout are counted in the new active bank and do not change the words being read out.
- R9: `rd_count` is 0 in every cycle in which `rd_valid` is low.
- R10: `busy` stays high through the last readout read and is low again in the cycle that carries the last readout word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ev_valid | input | 1 | Photon event present this cycle |
| ev_pix | input | PIX_W (1) | Pixel number within the memory pair |
| ev_time | input | TIME_W (10) | Arrival-time code |
| swap_req | input | 1 | Request to exchange active and idle banks |
| active_bank | output | 1 | Bank currently accumulating |
| busy | output | 1 | Power-up clear or readout in progress |
| swap_err | output | 1 | One-cycle flag: a swap was refused |
| rd_valid | output | 1 | Readout word present |
| rd_pix | output | PIX_W (1) | Pixel of the readout word |
| rd_bin | output | BIN_W (7) | Bin of the readout word |
| rd_count | output | CNT_W (16) | Bin count of the readout word |

## Verification
Several properties are checked on every cycle: accepted swaps toggle the bank, refused swaps raise the error flag and hold the bank, readout labels start at zero and step by one, an increment never wraps a count to zero, and the two memory ports never write the same location in the same cycle. Only the directed scenarios can show that the counts themselves are right. That covers forwarding on back-to-back same-bin hits, saturation after 65,540 hits, clearing across two readouts of one bank, the ownership of an event that coincides with a swap, and the isolation between the bank being drained and the bank accumulating during the drain.

// File: rtl/hist_pkg.sv
// Shared definitions for the ping-pong histogrammer.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package hist_pkg;

    // Port-B sequencer modes: power-up clear, waiting for swap,
    // settle gap after swap, readout-with-clear sweep.
    typedef enum logic [1:0] {
        DR_INIT  = 2'd0,
        DR_IDLE  = 2'd1,
        DR_WAIT  = 2'd2,
        DR_SWEEP = 2'd3
    } drain_state_t;

endpackage

// File: rtl/hist_dpram.sv
// Two-port histogram memory model.
// Port A: registered read at one address plus a write at another address
// every cycle (accumulation side). Port B: read-first access with optional
// write (readout and clear side). The array is not reset; the owner clears it.
// Assumes: the two ports never write the same word in one cycle.
module hist_dpram #(
    parameter int DW = 16,
    parameter int AW = 9
) (
    input  logic          clk,
    input  logic [AW-1:0] a_raddr,
    output logic [DW-1:0] a_rdata,
    input  logic          a_we,
    input  logic [AW-1:0] a_waddr,
    input  logic [DW-1:0] a_wdata,
    input  logic [AW-1:0] b_addr,
    input  logic          b_we,
    input  logic [DW-1:0] b_wdata,
    output logic [DW-1:0] b_rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Both ports: registered reads sample the old content, then writes land.
    always_ff @(posedge clk) begin
        a_rdata <= mem[a_raddr];
        b_rdata <= mem[b_addr];
        if (a_we) begin
            mem[a_waddr] <= a_wdata;
        end
        if (b_we) begin
            mem[b_addr] <= b_wdata;
        end
    end

endmodule

// File: rtl/hist_accum.sv
// Read-modify-write accumulator on memory port A.
// Cycle 0: the event address is issued as a read. Cycle 1: the returned
// count (or the write from the previous cycle when the address matches)
// is incremented with saturation and written back.
// Assumes: memory read latency of one cycle; a write issued in a cycle is
// not visible to the read issued in that same cycle.
module hist_accum #(
    parameter int TIME_W = 10,
    parameter int BIN_W  = 7,
    parameter int PIX_W  = 1,
    parameter int CNT_W  = 16,
    localparam int AW    = 1 + PIX_W + BIN_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              bank,
    input  logic              ev_valid,
    input  logic [PIX_W-1:0]  ev_pix,
    input  logic [TIME_W-1:0] ev_time,
    output logic [AW-1:0]     mem_raddr,
    input  logic [CNT_W-1:0]  mem_rdata,
    output logic              mem_we,
    output logic [AW-1:0]     mem_waddr,
    output logic [CNT_W-1:0]  mem_wdata
);
    logic              s1_v;
    logic [AW-1:0]     s1_addr;
    logic              fw_v;
    logic [AW-1:0]     fw_addr;
    logic [CNT_W-1:0]  fw_data;
    logic [CNT_W-1:0]  base;

    // Issue stage: bin is the top BIN_W bits of the time code.
    always_comb begin
        mem_raddr = {bank, ev_pix, ev_time[TIME_W-1 -: BIN_W]};
    end

    // Update stage: forward the one in-flight write, then saturating increment.
    always_comb begin
        base      = (fw_v && (fw_addr == s1_addr)) ? fw_data : mem_rdata;
        mem_we    = s1_v;
        mem_waddr = s1_addr;
        mem_wdata = (&base) ? base : base + 1'b1;
    end

    // Pipeline and forwarding registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v    <= 1'b0;
            s1_addr <= '0;
            fw_v    <= 1'b0;
            fw_addr <= '0;
            fw_data <= '0;
        end else begin
            s1_v    <= ev_valid && enable;
            s1_addr <= mem_raddr;
            fw_v    <= mem_we;
            fw_addr <= mem_waddr;
            fw_data <= mem_wdata;
        end
    end

endmodule

// File: rtl/hist_drain.sv
// Port-B sequencer: clears the whole memory after reset, owns the active-bank
// bit, accepts or refuses swaps, and sweeps the idle bank with read-and-clear.
// The sweep starts two cycles after an accepted swap, so the last accumulator
// writes into the old bank have landed before it is read.
// Assumes: memory port B is read-first with one cycle of read latency.
module hist_drain #(
    parameter int BIN_W = 7,
    parameter int PIX_W = 1,
    parameter int CNT_W = 16,
    localparam int AW   = 1 + PIX_W + BIN_W,
    localparam int IW   = PIX_W + BIN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             swap_req,
    output logic             active_bank,
    output logic             busy,
    output logic             init_busy,
    output logic             swap_err,
    output logic [AW-1:0]    mem_addr,
    output logic             mem_we,
    input  logic [CNT_W-1:0] mem_rdata,
    output logic             rd_valid,
    output logic [PIX_W-1:0] rd_pix,
    output logic [BIN_W-1:0] rd_bin,
    output logic [CNT_W-1:0] rd_count
);
    import hist_pkg::*;

    drain_state_t  state;
    logic [AW-1:0] cnt;
    logic          rd_v;
    logic [IW-1:0] rd_idx;

    // Port-B address: whole memory during init, idle bank during the sweep.
    always_comb begin
        mem_addr  = (state == DR_INIT) ? cnt : {~active_bank, cnt[IW-1:0]};
        mem_we    = (state == DR_INIT) || (state == DR_SWEEP);
        busy      = (state != DR_IDLE);
        init_busy = (state == DR_INIT);
    end

    // Readout word outputs, count forced to zero when no word is present.
    always_comb begin
        rd_valid = rd_v;
        rd_pix   = rd_idx[IW-1 -: PIX_W];
        rd_bin   = rd_idx[BIN_W-1:0];
        rd_count = rd_v ? mem_rdata : '0;
    end

    // Sequencer, bank ownership and swap arbitration.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= DR_INIT;
            cnt         <= '0;
            active_bank <= 1'b0;
            swap_err    <= 1'b0;
            rd_v        <= 1'b0;
            rd_idx      <= '0;
        end else begin
            swap_err <= swap_req && (state != DR_IDLE);
            rd_v     <= (state == DR_SWEEP);
            rd_idx   <= cnt[IW-1:0];
            unique case (state)
                DR_INIT: begin
                    cnt <= cnt + 1'b1;
                    if (&cnt) begin
                        state <= DR_IDLE;
                    end
                end
                DR_IDLE: begin
                    if (swap_req) begin
                        active_bank <= ~active_bank;
                        cnt         <= '0;
                        state       <= DR_WAIT;
                    end
                end
                DR_WAIT: begin
                    state <= DR_SWEEP;
                end
                DR_SWEEP: begin
                    cnt <= cnt + 1'b1;
                    if (&cnt[IW-1:0]) begin
                        cnt   <= '0;
                        state <= DR_IDLE;
                    end
                end
                default: state <= DR_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hist_pingpong_top.sv
// Double-buffered arrival-time histogrammer for a pair of pixels.
// Port A of the memory accumulates events into the active bank; port B
// drains and clears the idle bank after each accepted swap.
// Assumes: events arrive at most one per cycle; the readout stream has no
// back-pressure.
module hist_pingpong_top #(
    parameter int TIME_W = 10,
    parameter int BIN_W  = 7,
    parameter int PIX_W  = 1,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [PIX_W-1:0]  ev_pix,
    input  logic [TIME_W-1:0] ev_time,
    input  logic              swap_req,
    output logic              active_bank,
    output logic              busy,
    output logic              swap_err,
    output logic              rd_valid,
    output logic [PIX_W-1:0]  rd_pix,
    output logic [BIN_W-1:0]  rd_bin,
    output logic [CNT_W-1:0]  rd_count
);
    localparam int ADDR_W = 1 + PIX_W + BIN_W;

    logic [ADDR_W-1:0] a_raddr;
    logic [CNT_W-1:0]  a_rdata;
    logic              a_we;
    logic [ADDR_W-1:0] a_waddr;
    logic [CNT_W-1:0]  a_wdata;
    logic [ADDR_W-1:0] b_addr;
    logic              b_we;
    logic [CNT_W-1:0]  b_rdata;
    logic              init_busy;

    hist_accum #(
        .TIME_W(TIME_W), .BIN_W(BIN_W), .PIX_W(PIX_W), .CNT_W(CNT_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (!init_busy),
        .bank      (active_bank),
        .ev_valid  (ev_valid),
        .ev_pix    (ev_pix),
        .ev_time   (ev_time),
        .mem_raddr (a_raddr),
        .mem_rdata (a_rdata),
        .mem_we    (a_we),
        .mem_waddr (a_waddr),
        .mem_wdata (a_wdata)
    );

    hist_drain #(
        .BIN_W(BIN_W), .PIX_W(PIX_W), .CNT_W(CNT_W)
    ) u_drain (
        .clk         (clk),
        .rst_n       (rst_n),
        .swap_req    (swap_req),
        .active_bank (active_bank),
        .busy        (busy),
        .init_busy   (init_busy),
        .swap_err    (swap_err),
        .mem_addr    (b_addr),
        .mem_we      (b_we),
        .mem_rdata   (b_rdata),
        .rd_valid    (rd_valid),
        .rd_pix      (rd_pix),
        .rd_bin      (rd_bin),
        .rd_count    (rd_count)
    );

    hist_dpram #(
        .DW(CNT_W), .AW(ADDR_W)
    ) u_mem (
        .clk     (clk),
        .a_raddr (a_raddr),
        .a_rdata (a_rdata),
        .a_we    (a_we),
        .a_waddr (a_waddr),
        .a_wdata (a_wdata),
        .b_addr  (b_addr),
        .b_we    (b_we),
        .b_wdata ('0),
        .b_rdata (b_rdata)
    );

endmodule

// File: rtl/hist_pingpong_chk.sv
// Property checker for hist_pingpong_top, attached with bind below.
// Assumes: synchronous active-low reset on rst_n.
module hist_pingpong_chk #(
    parameter int PIX_W  = 1,
    parameter int BIN_W  = 7,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic              swap_req,
    input logic              busy,
    input logic              active_bank,
    input logic              swap_err,
    input logic              rd_valid,
    input logic [PIX_W-1:0]  rd_pix,
    input logic [BIN_W-1:0]  rd_bin,
    input logic              a_we,
    input logic [ADDR_W-1:0] a_waddr,
    input logic [CNT_W-1:0]  a_wdata,
    input logic              b_we,
    input logic [ADDR_W-1:0] b_addr
);
    AST_SWAP_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req && !busy |=> active_bank != $past(active_bank)); // R5
    AST_SWAP_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        swap_req && busy |=> swap_err && $stable(active_bank)); // R7
    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        swap_err |-> $past(swap_req && busy)); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        a_we |-> a_wdata != '0); // R4
    AST_PORT_CLASH: assert property (@(posedge clk) disable iff (!rst_n)
        a_we && b_we |-> a_waddr != b_addr); // R6
    AST_RD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_valid) |-> {rd_pix, rd_bin} == '0); // R5
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && $past(rd_valid) |-> {rd_pix, rd_bin} == $past({rd_pix, rd_bin}) + 1'b1); // R5
endmodule

bind hist_pingpong_top hist_pingpong_chk #(
    .PIX_W(PIX_W), .BIN_W(BIN_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .swap_req    (swap_req),
    .busy        (busy),
    .active_bank (active_bank),
    .swap_err    (swap_err),
    .rd_valid    (rd_valid),
    .rd_pix      (rd_pix),
    .rd_bin      (rd_bin),
    .a_we        (a_we),
    .a_waddr     (a_waddr),
    .a_wdata     (a_wdata),
    .b_we        (b_we),
    .b_addr      (b_addr)
);

// File: tb/hist_pingpong_top_test.sv
// Directed bench: one task per scenario, each checking its own results.
module hist_pingpong_top_test;
    localparam int NBIN = 128;
    localparam int NWORD = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ev_valid = 1'b0;
    logic [0:0] ev_pix = '0;
    logic [9:0] ev_time = '0;
    logic       swap_req = 1'b0;
    logic       active_bank;
    logic       busy;
    logic       swap_err;
    logic       rd_valid;
    logic [0:0] rd_pix;
    logic [6:0] rd_bin;
    logic [15:0] rd_count;

    int n_chk = 0;
    int n_bad = 0;
    int expc [2][2][NBIN];
    int bank_m = 0;

    always #4 clk = ~clk;

    hist_pingpong_top uut (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_pix(ev_pix),
        .ev_time(ev_time), .swap_req(swap_req), .active_bank(active_bank),
        .busy(busy), .swap_err(swap_err), .rd_valid(rd_valid),
        .rd_pix(rd_pix), .rd_bin(rd_bin), .rd_count(rd_count)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input int act, input int exp_v);
        n_chk++;
        if (act != exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // Present one event for one cycle; model it when counted.
    task automatic send(input int pix, input int tcode, input bit counted);
        ev_valid = 1'b1;
        ev_pix   = pix[0:0];
        ev_time  = tcode[9:0];
        if (counted && expc[bank_m][pix][tcode / 8] < 65535)
            expc[bank_m][pix][tcode / 8]++;
        tick();
        ev_valid = 1'b0;
    endtask

    // Swap, then watch the whole readout. Optional extras: an event in the
    // swap cycle, a refused swap mid-readout, events during the readout.
    task automatic swap_and_drain(input bit ev_on_swap, input bit probe, input bit ev_during);
        int old_b;
        old_b = bank_m;
        swap_req = 1'b1;
        if (ev_on_swap) begin
            ev_valid = 1'b1; ev_pix = 1'b0; ev_time = 10'd8;
            if (expc[old_b][0][1] < 65535) expc[old_b][0][1]++;
        end
        tick();
        swap_req = 1'b0;
        ev_valid = 1'b0;
        bank_m = 1 - old_b;
        for (int k = 1; k <= 258; k++) begin
            if (k == 1) begin
                chk("R5 bank toggles", int'(active_bank), bank_m);
                chk("R5 busy rises", int'(busy), 1);
            end
            if (k < 3) begin
                chk("R9 no word before start", int'(rd_valid), 0);
                chk("R9 count zero when idle", int'(rd_count), 0);
            end else begin
                chk("R5 word valid", int'(rd_valid), 1);
                chk("R5 word index", int'({rd_pix, rd_bin}), k - 3);
                chk("R8 drained count", int'(rd_count), expc[old_b][(k - 3) / NBIN][(k - 3) % NBIN]);
            end
            if (probe && k == 6) begin
                chk("R7 refused flag", int'(swap_err), 1);
                chk("R7 bank held", int'(active_bank), bank_m);
            end
            if (k == 257) chk("R10 busy through last read", int'(busy), 1);
            if (k == 258) chk("R10 busy low at last word", int'(busy), 0);
            swap_req = (probe && k == 5);
            if (ev_during && k >= 2 && k < 200 && (k % 3) != 0) begin
                ev_valid = 1'b1;
                ev_pix   = k[0:0];
                ev_time  = 10'((k * 37 + 5) % 1024);
                if (expc[bank_m][k % 2][((k * 37 + 5) % 1024) / 8] < 65535)
                    expc[bank_m][k % 2][((k * 37 + 5) % 1024) / 8]++;
            end else begin
                ev_valid = 1'b0;
            end
            tick();
        end
        swap_req = 1'b0;
        ev_valid = 1'b0;
        chk("R9 count zero after burst", int'(rd_count), 0);
        for (int p = 0; p < 2; p++)
            for (int b = 0; b < NBIN; b++)
                expc[old_b][p][b] = 0; // R6: drained bank is now empty
    endtask

    task automatic t_reset();
        int n;
        rst_n = 1'b0;
        repeat (3) tick();
        chk("R1 bank in reset", int'(active_bank), 0);
        chk("R1 valid in reset", int'(rd_valid), 0);
        chk("R1 err in reset", int'(swap_err), 0);
        chk("R1 busy in reset", int'(busy), 1);
        rst_n = 1'b1;
        n = 0;
        while (busy && n < 2000) begin
            if (n == 10 || n == 11) begin
                ev_valid = 1'b1; ev_pix = 1'b0; ev_time = 10'd100;
            end else begin
                ev_valid = 1'b0;
            end
            tick();
            n++;
        end
        ev_valid = 1'b0;
        chk("R1 init length", n, 512);
        chk("R1 bank after init", int'(active_bank), 0);
    endtask

    task automatic t_basic();
        send(0, 0, 1);
        send(0, 7, 1);     // R2: same bin as time 0
        send(0, 8, 1);
        send(1, 1023, 1);
        send(1, 100, 1);
        tick();
        send(0, 515, 1);
        send(1, 103, 1);   // R2: bin 12 again
        swap_and_drain(0, 0, 0);
    endtask

    task automatic t_backtoback();
        for (int i = 0; i < 6; i++) send(1, 77, 1);  // R3 same bin every cycle
        send(0, 77, 1);
        send(1, 77, 1);
        send(1, 78, 1);
        send(1, 79, 1);
        for (int i = 0; i < 4; i++) send(i % 2, 640, 1);
        swap_and_drain(0, 1, 1);
    endtask

    task automatic t_clear();
        send(1, 300, 1);
        swap_and_drain(1, 0, 0);  // R6: only events since last drain appear
    endtask

    task automatic t_sat();
        for (int i = 0; i < 65540; i++) send(1, 1016, 1); // R4
        send(0, 1016, 1);
        chk("R4 model saturated", expc[bank_m][1][127], 65535);
        swap_and_drain(0, 0, 0);
    endtask

    initial begin
        for (int p = 0; p < 2; p++)
            for (int b = 0; b < NBIN; b++) begin
                expc[0][p][b] = 0;
                expc[1][p][b] = 0;
            end
        t_reset();
        t_basic();
        t_backtoback();
        t_clear();
        t_sat();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule